// File: doc/BRIEF.md
# Effective Address and Cycle Calculator

This block computes operand addresses for an 8-bit processor with a 16-bit address space. The caller hands it an addressing mode code, the address of the instruction's opcode byte, and the two index register values. The block then reads the operand bytes that follow the opcode through a byte-wide memory read port. Where the mode needs it, it also reads a two-byte pointer. It returns the final effective address, the instruction length in bytes and the instruction's cycle cost. The cycle cost includes the one-cycle penalty that indexed reads pay when the index moves the address into another page. Jump targets and relative branch targets come out on the same effective-address output.

The request side is a valid/ready pair. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a calculation runs, `req_ready` stays low and `req_valid` is ignored, so a caller that wants to be served must hold `req_valid` until it sees `req_ready`. The result side has no back-pressure. `res_valid` is a pulse of one cycle, and the result outputs are meaningful only in that cycle. The memory port is plain: `mem_rd` with `mem_addr` asks for one byte, and that byte must be on `mem_rdata` in the next cycle.

Top module: `ea_calc_unit`

## Requirements
- R1: `req_ready` is high after reset and whenever the unit is idle. A request is accepted only when `req_valid` and `req_ready` are both high. Once a request is accepted, `req_ready` stays low until the result has been delivered, and `req_valid` raised during that time is ignored and starts no work. `res_valid` is high for exactly one cycle per accepted request.
- R2: Mode codes on `req_mode` are: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 pre-indexed indirect (zp,X), 10 post-indexed indirect (zp),Y, 11 absolute jump, 12 indirect jump, 13 relative branch. Codes 14 and 15 act as implied. `res_len` is 1 for implied-like and accumulator modes, 3 for codes 6, 7, 8, 11 and 12, and 2 for all other codes.
- R3: Zero page gives {0x00, op}, costing 3 cycles. Zero page+X and +Y give {0x00, (op + index) mod 256}, costing 4 cycles.
- R4: Absolute modes read a little-endian base from opcode+1 and opcode+2. Absolute costs 4 cycles. Absolute+X and +Y add the index to the full 16-bit base and cost 4 cycles, or 5 cycles when the high byte of the sum differs from the high byte of the base.
- R5: (zp,X) reads the pointer low byte at {0x00, (op+X) mod 256} and the high byte at the next zero-page byte, wrapping within page 0. The pointer is the effective address, at 6 cycles.
- R6: (zp),Y reads its pointer at {0x00, op} and at the next zero-page byte, wrapping within page 0. It adds Y to the full pointer and costs 5 cycles, or 6 when the high byte changes.
- R7: Absolute jump yields the two operand bytes as the target, at 3 cycles. Indirect jump reads the target low byte at the operand address P and the high byte at {P high byte, (P low byte + 1) mod 256}, at 5 cycles.
- R8: A relative branch yields opcode address + 2 plus the operand byte sign-extended from bit 7, with a 16-bit wrap, at 2 cycles.
- R9: Immediate yields opcode address + 1 and reads no memory. Implied, accumulator and codes 14 and 15 yield 0x0000 and read no memory. All of these cost 2 cycles.
- R10: `mem_rd` is high only while a calculation runs, for at most one address per cycle. The number of reads per request is 0 for codes 0, 1, 2, 14 and 15; 1 for codes 3, 4, 5 and 13; 2 for codes 6, 7, 8 and 11; 3 for codes 9 and 10; and 4 for code 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 4 | Addressing mode code |
| req_pc | input | 16 | Address of the opcode byte |
| req_x | input | 8 | X index value |
| req_y | input | 8 | Y index value |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| res_valid | output | 1 | Result pulse |
| res_ea | output | 16 | Effective address or branch/jump target |
| res_len | output | 2 | Instruction length in bytes |
| res_cycles | output | 3 | Instruction cycle cost |

## Verification
The assertions take it for granted that the memory returns the requested byte exactly one cycle after `mem_rd`, whatever the address. They also assume that `req_mode`, `req_pc`, `req_x` and `req_y` are valid only on the cycle of acceptance. The bench memory model answers every strobe on the next edge from a sparse byte store. Each request holds `req_valid` for just the accepting cycle. A deliberate request raised while the unit is busy checks that it is dropped and never queued.

// File: rtl/ea_calc_pkg.sv
package ea_calc_pkg;

  localparam int LEN_W = 2;
  localparam int CYC_W = 3;

  typedef enum logic [3:0] {
    AM_NONE   = 4'd0,
    AM_ACC    = 4'd1,
    AM_IMM    = 4'd2,
    AM_ZP     = 4'd3,
    AM_ZPX    = 4'd4,
    AM_ZPY    = 4'd5,
    AM_ABS    = 4'd6,
    AM_ABSX   = 4'd7,
    AM_ABSY   = 4'd8,
    AM_PREX   = 4'd9,
    AM_POSTY  = 4'd10,
    AM_JMPA   = 4'd11,
    AM_JMPI   = 4'd12,
    AM_BRANCH = 4'd13
  } amode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OP_LO,
    ST_OP_HI,
    ST_GET_LO,
    ST_GET_HI,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_PTR_END,
    ST_DONE
  } fetch_st_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [CYC_W-1:0] base_cyc;
    logic [1:0]       n_op;
    logic             use_ptr;
    logic             pen_en;
  } mprops_t;

endpackage

// File: rtl/ea_mode_props.sv
module ea_mode_props
  import ea_calc_pkg::*;
(
  input  logic [3:0] mode_i,
  output mprops_t    props_o
);

  always_comb begin
    props_o.len      = LEN_W'(1);
    props_o.base_cyc = CYC_W'(2);
    props_o.n_op     = 2'd0;
    props_o.use_ptr  = 1'b0;
    props_o.pen_en   = 1'b0;
    case (amode_e'(mode_i))
      AM_IMM: begin
        props_o.len = LEN_W'(2);
      end
      AM_ZP: begin
        props_o.len      = LEN_W'(2);
        props_o.base_cyc = CYC_W'(3);
        props_o.n_op     = 2'd1;
      end
      AM_ZPX, AM_ZPY: begin
        props_o.len      = LEN_W'(2);
        props_o.base_cyc = CYC_W'(4);
        props_o.n_op     = 2'd1;
      end
      AM_ABS: begin
        props_o.len      = LEN_W'(3);
        props_o.base_cyc = CYC_W'(4);
        props_o.n_op     = 2'd2;
      end
      AM_ABSX, AM_ABSY: begin
        props_o.len      = LEN_W'(3);
        props_o.base_cyc = CYC_W'(4);
        props_o.n_op     = 2'd2;
        props_o.pen_en   = 1'b1;
      end
      AM_PREX: begin
        props_o.len      = LEN_W'(2);
        props_o.base_cyc = CYC_W'(6);
        props_o.n_op     = 2'd1;
        props_o.use_ptr  = 1'b1;
      end
      AM_POSTY: begin
        props_o.len      = LEN_W'(2);
        props_o.base_cyc = CYC_W'(5);
        props_o.n_op     = 2'd1;
        props_o.use_ptr  = 1'b1;
        props_o.pen_en   = 1'b1;
      end
      AM_JMPA: begin
        props_o.len      = LEN_W'(3);
        props_o.base_cyc = CYC_W'(3);
        props_o.n_op     = 2'd2;
      end
      AM_JMPI: begin
        props_o.len      = LEN_W'(3);
        props_o.base_cyc = CYC_W'(5);
        props_o.n_op     = 2'd2;
        props_o.use_ptr  = 1'b1;
      end
      AM_BRANCH: begin
        props_o.len  = LEN_W'(2);
        props_o.n_op = 2'd1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ea_addr_unit.sv
module ea_addr_unit
  import ea_calc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  amode_e              mode_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [DATA_W-1:0]   x_i,
  input  logic [DATA_W-1:0]   y_i,
  input  logic [DATA_W-1:0]   op_lo_i,
  input  logic [DATA_W-1:0]   op_hi_i,
  input  logic [DATA_W-1:0]   ptr_lo_i,
  input  logic [DATA_W-1:0]   ptr_hi_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic                crossed_o
);

  localparam logic [DATA_W-1:0] PAGE0 = '0;

  logic [ADDR_W-1:0] opw, ptrw, x_w, y_w, rel_w;
  logic [DATA_W-1:0] zp_x, zp_y;

  assign opw   = {op_hi_i, op_lo_i};
  assign ptrw  = {ptr_hi_i, ptr_lo_i};
  assign x_w   = {PAGE0, x_i};
  assign y_w   = {PAGE0, y_i};
  assign rel_w = {{DATA_W{op_lo_i[DATA_W-1]}}, op_lo_i};
  assign zp_x  = op_lo_i + x_i;
  assign zp_y  = op_lo_i + y_i;

  always_comb begin
    ea_o      = '0;
    crossed_o = 1'b0;
    case (mode_i)
      AM_IMM:         ea_o = pc_i + ADDR_W'(1);
      AM_ZP:          ea_o = {PAGE0, op_lo_i};
      AM_ZPX:         ea_o = {PAGE0, zp_x};
      AM_ZPY:         ea_o = {PAGE0, zp_y};
      AM_ABS, AM_JMPA: ea_o = opw;
      AM_ABSX: begin
        ea_o      = opw + x_w;
        crossed_o = (ea_o[ADDR_W-1:DATA_W] != op_hi_i);
      end
      AM_ABSY: begin
        ea_o      = opw + y_w;
        crossed_o = (ea_o[ADDR_W-1:DATA_W] != op_hi_i);
      end
      AM_PREX, AM_JMPI: ea_o = ptrw;
      AM_POSTY: begin
        ea_o      = ptrw + y_w;
        crossed_o = (ea_o[ADDR_W-1:DATA_W] != ptr_hi_i);
      end
      AM_BRANCH:      ea_o = pc_i + ADDR_W'(2) + rel_w;
      default:        ea_o = '0;
    endcase
  end

endmodule

// File: rtl/ea_fetch_seq.sv
module ea_fetch_seq
  import ea_calc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_x,
  input  logic [DATA_W-1:0] req_y,
  input  mprops_t           req_props,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output amode_e            mode_q,
  output mprops_t           props_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic [DATA_W-1:0] op_lo,
  output logic [DATA_W-1:0] op_hi,
  output logic [DATA_W-1:0] ptr_lo,
  output logic [DATA_W-1:0] ptr_hi
);

  localparam logic [DATA_W-1:0] ONE_B = DATA_W'(1);
  localparam logic [DATA_W-1:0] PAGE0 = '0;

  fetch_st_e         state;
  logic [ADDR_W-1:0] ptr_a;
  logic [DATA_W-1:0] prex_lo;

  assign prex_lo = op_lo + x_q;

  always_comb begin
    case (mode_q)
      AM_JMPI: ptr_a = {op_hi, op_lo};
      AM_PREX: ptr_a = {PAGE0, prex_lo};
      default: ptr_a = {PAGE0, op_lo};
    endcase
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    done      = (state == ST_DONE);
    mem_rd    = 1'b0;
    mem_addr  = '0;
    case (state)
      ST_OP_LO: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(1);
      end
      ST_OP_HI: begin
        mem_rd   = 1'b1;
        mem_addr = pc_q + ADDR_W'(2);
      end
      ST_PTR_LO: begin
        mem_rd   = 1'b1;
        mem_addr = ptr_a;
      end
      ST_PTR_HI: begin
        mem_rd   = 1'b1;
        mem_addr = {ptr_a[ADDR_W-1:DATA_W], ptr_a[DATA_W-1:0] + ONE_B};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= AM_NONE;
      props_q <= '0;
      pc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      op_lo   <= '0;
      op_hi   <= '0;
      ptr_lo  <= '0;
      ptr_hi  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q  <= amode_e'(req_mode);
            props_q <= req_props;
            pc_q    <= req_pc;
            x_q     <= req_x;
            y_q     <= req_y;
            op_lo   <= '0;
            op_hi   <= '0;
            ptr_lo  <= '0;
            ptr_hi  <= '0;
            state   <= (req_props.n_op == 2'd0) ? ST_DONE : ST_OP_LO;
          end
        end
        ST_OP_LO:   state <= (props_q.n_op == 2'd2) ? ST_OP_HI : ST_GET_LO;
        ST_OP_HI: begin
          op_lo <= mem_rdata;
          state <= ST_GET_HI;
        end
        ST_GET_LO: begin
          op_lo <= mem_rdata;
          state <= props_q.use_ptr ? ST_PTR_LO : ST_DONE;
        end
        ST_GET_HI: begin
          op_hi <= mem_rdata;
          state <= props_q.use_ptr ? ST_PTR_LO : ST_DONE;
        end
        ST_PTR_LO:  state <= ST_PTR_HI;
        ST_PTR_HI: begin
          ptr_lo <= mem_rdata;
          state  <= ST_PTR_END;
        end
        ST_PTR_END: begin
          ptr_hi <= mem_rdata;
          state  <= ST_DONE;
        end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  rd_busy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);

  // R7
  ptr_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTR_HI) |-> (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])));

endmodule

// File: rtl/ea_calc_unit.sv
module ea_calc_unit
  import ea_calc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_x,
  input  logic [DATA_W-1:0] req_y,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_ea,
  output logic [LEN_W-1:0]  res_len,
  output logic [CYC_W-1:0]  res_cycles
);

  mprops_t           req_props, props_q;
  amode_e            mode_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] x_q, y_q, op_lo, op_hi, ptr_lo, ptr_hi;
  logic              crossed;

  ea_mode_props u_props (
    .mode_i  (req_mode),
    .props_o (req_props)
  );

  ea_fetch_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .req_pc    (req_pc),
    .req_x     (req_x),
    .req_y     (req_y),
    .req_props (req_props),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .done      (res_valid),
    .mode_q    (mode_q),
    .props_q   (props_q),
    .pc_q      (pc_q),
    .x_q       (x_q),
    .y_q       (y_q),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .ptr_lo    (ptr_lo),
    .ptr_hi    (ptr_hi)
  );

  ea_addr_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .mode_i    (mode_q),
    .pc_i      (pc_q),
    .x_i       (x_q),
    .y_i       (y_q),
    .op_lo_i   (op_lo),
    .op_hi_i   (op_hi),
    .ptr_lo_i  (ptr_lo),
    .ptr_hi_i  (ptr_hi),
    .ea_o      (res_ea),
    .crossed_o (crossed)
  );

  assign res_len    = props_q.len;
  assign res_cycles = props_q.base_cyc + CYC_W'(props_q.pen_en && crossed);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len >= LEN_W'(1) && res_len <= LEN_W'(3)));

  // R3
  zp_page0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
      |-> (res_ea[ADDR_W-1:DATA_W] == '0));

  // R6
  six_cycle_modes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_cycles > CYC_W'(5)) |-> (mode_q == AM_PREX || mode_q == AM_POSTY));

endmodule

// File: tb/test_ea_calc_unit.sv
module test_ea_calc_unit;

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] pc;
    logic [7:0]  x;
    logic [7:0]  y;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [15:0] a0;
    logic [7:0]  d0;
    logic [15:0] a1;
    logic [7:0]  d1;
    logic [15:0] ea;
    logic [1:0]  len;
    logic [2:0]  cyc;
    logic [2:0]  nrd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  16'h1000, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0000, 2'd1, 3'd2, 3'd0},
    '{4'd1,  16'h1100, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0000, 2'd1, 3'd2, 3'd0},
    '{4'd2,  16'h2000, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h2001, 2'd2, 3'd2, 3'd0},
    '{4'd3,  16'h0300, 8'h00, 8'h00, 8'h42, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0042, 2'd2, 3'd3, 3'd1},
    '{4'd4,  16'h0400, 8'h20, 8'h00, 8'hF0, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0010, 2'd2, 3'd4, 3'd1},
    '{4'd5,  16'h0410, 8'h00, 8'h05, 8'h10, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0015, 2'd2, 3'd4, 3'd1},
    '{4'd6,  16'h0500, 8'h00, 8'h00, 8'h34, 8'h12, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h1234, 2'd3, 3'd4, 3'd2},
    '{4'd7,  16'h0510, 8'h05, 8'h00, 8'h10, 8'h20, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h2015, 2'd3, 3'd4, 3'd2},
    '{4'd7,  16'h0520, 8'h01, 8'h00, 8'hFF, 8'h20, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h2100, 2'd3, 3'd5, 3'd2},
    '{4'd8,  16'h0530, 8'h00, 8'h80, 8'h80, 8'h30, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h3100, 2'd3, 3'd5, 3'd2},
    '{4'd8,  16'h0540, 8'h00, 8'h7F, 8'h80, 8'h30, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h30FF, 2'd3, 3'd4, 3'd2},
    '{4'd9,  16'h0600, 8'h01, 8'h00, 8'hFE, 8'h00, 16'h00FF, 8'h78, 16'h0000, 8'h56, 16'h5678, 2'd2, 3'd6, 3'd3},
    '{4'd9,  16'h0610, 8'h04, 8'h00, 8'h20, 8'h00, 16'h0024, 8'hCD, 16'h0025, 8'hAB, 16'hABCD, 2'd2, 3'd6, 3'd3},
    '{4'd10, 16'h0620, 8'h00, 8'h10, 8'h40, 8'h00, 16'h0040, 8'hF8, 16'h0041, 8'h12, 16'h1308, 2'd2, 3'd6, 3'd3},
    '{4'd10, 16'h0630, 8'h00, 8'h01, 8'hFF, 8'h00, 16'h00FF, 8'h00, 16'h0000, 8'h44, 16'h4401, 2'd2, 3'd5, 3'd3},
    '{4'd11, 16'h0700, 8'h00, 8'h00, 8'hCD, 8'hAB, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'hABCD, 2'd3, 3'd3, 3'd2},
    '{4'd12, 16'h0900, 8'h00, 8'h00, 8'hFF, 8'h30, 16'h30FF, 8'h11, 16'h3000, 8'h22, 16'h2211, 2'd3, 3'd5, 3'd4},
    '{4'd12, 16'h0910, 8'h00, 8'h00, 8'h00, 8'h31, 16'h3100, 8'h9A, 16'h3101, 8'hBC, 16'hBC9A, 2'd3, 3'd5, 3'd4},
    '{4'd13, 16'h0800, 8'h00, 8'h00, 8'h10, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0812, 2'd2, 3'd2, 3'd1},
    '{4'd13, 16'h0810, 8'h00, 8'h00, 8'hF0, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0802, 2'd2, 3'd2, 3'd1},
    '{4'd13, 16'h00FE, 8'h00, 8'h00, 8'h80, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0080, 2'd2, 3'd2, 3'd1},
    '{4'd14, 16'h1200, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFF0, 8'hEE, 16'hFFF1, 8'hEE, 16'h0000, 2'd1, 3'd2, 3'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        res_valid;
  logic [15:0] res_ea;
  logic [1:0]  res_len;
  logic [2:0]  res_cycles;

  int compared = 0;
  int mismatched = 0;
  int rd_total = 0;
  logic [7:0] mem [logic [15:0]];

  always #2 clk = ~clk;

  ea_calc_unit i_ea_calc_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mode   (req_mode),
    .req_pc     (req_pc),
    .req_x      (req_x),
    .req_y      (req_y),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .res_valid  (res_valid),
    .res_ea     (res_ea),
    .res_len    (res_len),
    .res_cycles (res_cycles)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'hEE;
      rd_total  <= rd_total + 1;
    end
  end

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd3, 4'd4, 4'd5:   return "R3";
      4'd6, 4'd7, 4'd8:   return "R4";
      4'd9:               return "R5";
      4'd10:              return "R6";
      4'd11, 4'd12:       return "R7";
      4'd13:              return "R8";
      default:            return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int t = 0;
    while (res_valid !== 1'b1 && t < 40) begin
      @(negedge clk);
      t++;
    end
    ok = (res_valid === 1'b1);
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    mem.delete();
    mem[v.pc + 16'd1] = v.b1;
    mem[v.pc + 16'd2] = v.b2;
    mem[v.a0] = v.d0;
    mem[v.a1] = v.d1;
    req_mode  = v.mode;
    req_pc    = v.pc;
    req_x     = v.x;
    req_y     = v.y;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit ok;
    int rd0;
    repeat (3) @(negedge clk);
    // R1 / R10 reset state
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "no result after reset", 32'(res_valid), 32'd0);
    chk("R10", "no read after reset", 32'(mem_rd), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      rd0 = rd_total;
      launch(VECS[i]);
      wait_done(ok);
      chk("R1", "result pulse seen", 32'(ok), 32'd1);
      chk(tag_of(VECS[i].mode), "effective address", 32'(res_ea), 32'(VECS[i].ea));
      chk("R2", "length", 32'(res_len), 32'(VECS[i].len));
      chk(tag_of(VECS[i].mode), "cycles", 32'(res_cycles), 32'(VECS[i].cyc));
      chk("R10", "read count", 32'(rd_total - rd0), 32'(VECS[i].nrd));
      @(negedge clk);
      chk("R1", "pulse lasts one cycle", 32'(res_valid), 32'd0);
    end

    // R1: request raised while busy is dropped
    launch(VECS[6]);
    chk("R1", "busy blocks ready", 32'(req_ready), 32'd0);
    req_mode  = 4'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(ok);
    chk("R1", "busy request ignored, result", 32'(res_ea), 32'h1234);
    chk("R1", "busy request ignored, cycles", 32'(res_cycles), 32'd4);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1", "no extra result", 32'(res_valid), 32'd0);
      chk("R10", "no read when idle", 32'(mem_rd), 32'd0);
    end
    chk("R1", "ready again", 32'(req_ready), 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule